// File: doc/BRIEF.md
# DTMF Steering Guard-Time Validator

This block sits behind a dual-tone detector. The detector raises a raw steering level while it recognises a tone pair. The block turns that level into a qualified digit-present output. The output rises only after the raw level has held for a tone-present guard time. Once high, it falls only after the raw level has stayed away for a tone-absent guard time. Because of this hysteresis, short noise bursts never register as digits, and brief dropouts in the middle of a digit never split it in two.

Time is measured in strobes on a timebase input, `tick_i`. With a 1 ms strobe and the default guard of 20 ticks, a burst of 20 ms or less is rejected and a burst of 40 ms or more is accepted. The same limits apply to gaps between digits.

A powerdown input holds the output low. It also clears all qualification progress, so a digit that is still present when powerdown is released must qualify again from the start.

The block carries no data stream, so every pin is a plain level or strobe with no handshake.

Top module: `dtmf_steer_guard`

## Requirements
- R1: During and right after reset, `steer_o` is 0 and no qualification progress is kept.
- R2: With `tone_i` held high, `steer_o` rises in the same clock edge that samples the (ON_GUARD+1)-th `tick_i` strobe seen while qualifying, and not before.
- R3: A burst of `tone_i` that spans at most ON_GUARD tick strobes never makes `steer_o` high.
- R4: If `tone_i` drops while a digit is qualifying, the present count is discarded, so the next burst needs the full ON_GUARD+1 strobes again.
- R5: Once `steer_o` is high, a drop of `tone_i` keeps it high until OFF_GUARD+1 tick strobes have been sampled with `tone_i` low; it falls on that strobe.
- R6: If `tone_i` returns while the absence is being counted, `steer_o` stays high and the absent count is discarded.
- R7: While `pwr_down_i` is 1, `steer_o` is 0 in the same cycle. Leaving powerdown restarts qualification from idle.
- R8: Clock cycles without a `tick_i` strobe never advance either guard count, however long `tone_i` is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timebase strobe, one cycle wide per time unit |
| tone_i | input | 1 | Raw early-steering level from the tone detector |
| pwr_down_i | input | 1 | Powerdown; 1 forces the output low and returns the block to idle |
| steer_o | output | 1 | Qualified digit-present output |

## Verification
The assertions assume that `tone_i`, `tick_i` and `pwr_down_i` are already synchronous to `clk_i`. They also assume that `tick_i` is a strobe and never a sustained level. The bench meets both assumptions by driving every input on the falling clock edge. It pulses `tick_i` for one cycle out of every four, and it changes `tone_i` only between strobes. Random burst and gap lengths are drawn on both sides of each guard limit, so the expected result of every draw follows directly from the tick count of that draw.

// File: rtl/dtmf_guard_pkg.sv
package dtmf_guard_pkg;
  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_QUAL_ON  = 2'd1,
    ST_VALID    = 2'd2,
    ST_QUAL_OFF = 2'd3
  } guard_state_e;
endpackage

// File: rtl/guard_tick_counter.sv
module guard_tick_counter #(
  parameter int WIDTH = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [WIDTH-1:0] count_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     count_o <= '0;
    else if (clr_i)  count_o <= '0;
    else if (inc_i)  count_o <= count_o + 1'b1;
  end

  // R8: the count moves only when the controller asks for a step.
  p_hold_without_step_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !inc_i) |=> $stable(count_o));
  p_step_by_one_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && inc_i) |=> (count_o == $past(count_o) + 1'b1));
endmodule

// File: rtl/guard_fsm.sv
module guard_fsm
  import dtmf_guard_pkg::*;
#(
  parameter int ON_GUARD  = 20,
  parameter int OFF_GUARD = 20,
  parameter int WIDTH     = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tone_i,
  input  logic             tick_i,
  input  logic             pd_i,
  input  logic [WIDTH-1:0] count_i,
  output logic             clr_o,
  output logic             inc_o,
  output logic             hold_o
);
  localparam logic [WIDTH-1:0] ON_LIM  = WIDTH'(ON_GUARD);
  localparam logic [WIDTH-1:0] OFF_LIM = WIDTH'(OFF_GUARD);
  localparam logic [WIDTH-1:0] TOP_LIM = (ON_GUARD > OFF_GUARD) ? ON_LIM : OFF_LIM;

  guard_state_e st_q, st_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  always_comb begin
    st_d  = st_q;
    clr_o = 1'b0;
    inc_o = 1'b0;
    if (pd_i) begin
      st_d  = ST_IDLE;
      clr_o = 1'b1;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          clr_o = 1'b1;
          if (tone_i) st_d = ST_QUAL_ON;
        end
        ST_QUAL_ON: begin
          if (!tone_i) begin
            st_d  = ST_IDLE;
            clr_o = 1'b1;
          end else if (tick_i) begin
            if (count_i == ON_LIM) begin
              st_d  = ST_VALID;
              clr_o = 1'b1;
            end else begin
              inc_o = 1'b1;
            end
          end
        end
        ST_VALID: begin
          clr_o = 1'b1;
          if (!tone_i) st_d = ST_QUAL_OFF;
        end
        ST_QUAL_OFF: begin
          if (tone_i) begin
            st_d  = ST_VALID;
            clr_o = 1'b1;
          end else if (tick_i) begin
            if (count_i == OFF_LIM) begin
              st_d  = ST_IDLE;
              clr_o = 1'b1;
            end else begin
              inc_o = 1'b1;
            end
          end
        end
        default: begin
          st_d  = ST_IDLE;
          clr_o = 1'b1;
        end
      endcase
    end
  end

  assign hold_o = (st_q == ST_VALID) || (st_q == ST_QUAL_OFF);

  p_rise_on_tick_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hold_o) |-> $past(tick_i && tone_i));
  p_fall_on_tick_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(hold_o) && !$past(pd_i)) |-> $past(tick_i && !tone_i));
  p_count_bounded_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_i <= TOP_LIM);
  p_drop_restarts_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_QUAL_ON && !tone_i && !pd_i) |=> (st_q == ST_IDLE && count_i == '0));
  p_return_keeps_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_QUAL_OFF && tone_i && !pd_i) |=> (hold_o && count_i == '0));
  p_pd_to_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_i |=> (!hold_o && count_i == '0));
endmodule

// File: rtl/dtmf_steer_guard.sv
module dtmf_steer_guard #(
  parameter int ON_GUARD  = 20,
  parameter int OFF_GUARD = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic tone_i,
  input  logic pwr_down_i,
  output logic steer_o
);
  localparam int MAX_GUARD = (ON_GUARD > OFF_GUARD) ? ON_GUARD : OFF_GUARD;
  localparam int CW        = (MAX_GUARD < 1) ? 1 : $clog2(MAX_GUARD + 1);

  logic [CW-1:0] count;
  logic          clr, inc, hold;

  guard_tick_counter #(.WIDTH(CW)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr),
    .inc_i   (inc),
    .count_o (count)
  );

  guard_fsm #(.ON_GUARD(ON_GUARD), .OFF_GUARD(OFF_GUARD), .WIDTH(CW)) u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tone_i  (tone_i),
    .tick_i  (tick_i),
    .pd_i    (pwr_down_i),
    .count_i (count),
    .clr_o   (clr),
    .inc_o   (inc),
    .hold_o  (hold)
  );

  assign steer_o = hold && !pwr_down_i;

  // R1: after reset, the first sampled output is low.
  p_reset_low_r1: assert property (@(posedge clk_i)
    !rst_ni |=> !steer_o);
endmodule

// File: tb/sim_dtmf_steer_guard.sv
module sim_dtmf_steer_guard;
  localparam int ON_G  = 20;
  localparam int OFF_G = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic tone = 1'b0;
  logic pd = 1'b0;
  logic steer;
  int   checks = 0;
  int   errors = 0;

  always #5 clk = ~clk;

  dtmf_steer_guard #(.ON_GUARD(ON_G), .OFF_GUARD(OFF_G)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .tone_i(tone),
    .pwr_down_i(pd), .steer_o(steer)
  );

  function automatic bit exp_accept(int strobes);
    return strobes > ON_G;
  endfunction

  function automatic bit exp_still_high(int gap_strobes);
    return gap_strobes <= OFF_G;
  endfunction

  task automatic chk(input bit exp, input string req);
    checks++;
    if (steer !== exp) begin
      errors++;
      $display("FAIL %s: steer_o=%0b expected %0b at %0t", req, steer, exp, $time);
    end
  endtask

  task automatic run_ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
      @(negedge clk);
      @(negedge clk);
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk(1'b0, "R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk(1'b0, "R1 after reset");

    // R8: no strobes, no progress
    tone = 1'b1;
    repeat (200) @(negedge clk);
    chk(1'b0, "R8 tone without ticks");
    run_ticks(ON_G);
    chk(1'b0, "R2 not before guard");
    run_ticks(1);
    chk(1'b1, "R2 rise on guard strobe");

    // R5 absence guard
    tone = 1'b0;
    run_ticks(OFF_G);
    chk(1'b1, "R5 held through absence guard");
    run_ticks(1);
    chk(1'b0, "R5 fall on guard strobe");

    // R4 drop during qualification
    tone = 1'b1;
    run_ticks(ON_G);
    tone = 1'b0;
    repeat (2) @(negedge clk);
    tone = 1'b1;
    run_ticks(ON_G);
    chk(1'b0, "R4 count restarted after drop");
    run_ticks(1);
    chk(1'b1, "R4 accepted after full guard");

    // R6 return during absence count
    tone = 1'b0;
    run_ticks(OFF_G);
    tone = 1'b1;
    repeat (2) @(negedge clk);
    chk(1'b1, "R6 stays high on return");
    tone = 1'b0;
    run_ticks(OFF_G);
    chk(1'b1, "R6 absent count restarted");
    run_ticks(1);
    chk(1'b0, "R6 fall after full guard");

    // R3 boundary burst
    tone = 1'b1;
    run_ticks(ON_G);
    tone = 1'b0;
    run_ticks(2);
    chk(1'b0, "R3 burst at guard rejected");

    // R7 powerdown
    tone = 1'b1;
    run_ticks(ON_G + 1);
    chk(1'b1, "R7 setup valid");
    @(negedge clk) pd = 1'b1;
    #1 chk(1'b0, "R7 low in same cycle");
    run_ticks(5);
    chk(1'b0, "R7 low while powered down");
    pd = 1'b0;
    run_ticks(ON_G);
    chk(1'b0, "R7 requalify after release");
    run_ticks(1);
    chk(1'b1, "R7 valid after full guard");
    tone = 1'b0;
    run_ticks(OFF_G + 1);
    chk(1'b0, "R5 back to idle");

    // random bursts and gaps around the limits
    for (int i = 0; i < 24; i++) begin
      int len = $urandom_range(2 * ON_G + 2, 1);
      int gap = $urandom_range(2 * OFF_G + 2, 1);
      tone = 1'b1;
      run_ticks(len);
      chk(exp_accept(len), exp_accept(len) ? "R2 random burst" : "R3 random burst");
      tone = 1'b0;
      run_ticks(gap);
      chk(exp_accept(len) && exp_still_high(gap), "R5 random gap");
      run_ticks(OFF_G + 1);
      chk(1'b0, "R5 random settle");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule